// File: doc/BRIEF.md
# Modular Exponentiation Engine Control Front End

This block is the memory-mapped control and status face of a public-key arithmetic engine. Software programs a set of registers over a simple 32-bit read/write port:

- the operation mode;
- the exponent and modulus bit lengths;
- the source address and byte count for the operand transfer.

It then launches a job through a start bit and polls a status register until the job is finished. The configuration fields go out on dedicated engine-side ports. The start request goes out as a single-cycle pulse.

The engine reports progress with two pulses, one for ready and one for complete. Each pulse sets a sticky status flag. A job is only finished when both flags are up. Software clears the flags by writing ones back to the status register. A single level interrupt combines the flags with their enable bits.

The block also decides who owns the operand SRAM. After a job, software sets an access bit to move the SRAM to the CPU bus. The move only takes effect while the engine is idle. Clearing the bit hands the SRAM back to the engine.

Top module: `rsa_fe_top`

## Requirements
- R1: After reset every register reads zero, and `eng_start`, `eng_dma`, `irq` and `sram_cpu_sel` are 0.
- R2: Configuration registers read back their writable fields only; all other bits read 0:
  - 0x4C source address: all 32 bits.
  - 0x50 length: bits 15:0.
  - 0x58 parameter: bits 31:0.
  - 0x48 control 3: bit 8 and bits 5:4.
  - 0x3F8 interrupt enable: bits 2:1.
- R3: The engine ports reflect the stored fields:
  - `eng_mode` is control 3 bits 5:4 (2 = ECC, 3 = RSA).
  - `eng_exp_bits` is parameter bits 31:16.
  - `eng_mod_bits` is parameter bits 15:0.
  - `eng_src_addr` is the source address register.
  - `eng_xfer_len` is length bits 15:0.
- R4: A write to control 1 (0x00) with bit 0 set while idle does three things. It raises `eng_start` for exactly the one cycle after the write. It marks the block busy. It loads bit 1 into `eng_dma`. Reading control 1 returns busy in bit 0 and the DMA select in bit 1.
- R5: A start write while busy produces no `eng_start` pulse and leaves busy set.
- R6: An `eng_ready` pulse sets status (0x3FC) bit 2. An `eng_done` pulse sets status bit 1 and clears busy. A finished job shows both bits set.
- R7: Writing the status register clears exactly the bits written as 1. A set pulse in the same cycle as the clear wins.
- R8: `irq` equals the OR over bits 2:1 of (status AND enable), registered one cycle after the status change.
- R9: `sram_cpu_sel` rises one cycle after control 3 bit 8 is 1 while idle. It stays 0 while busy. It falls one cycle after bit 8 is cleared.
- R10: Reads of unmapped offsets return 0. Writes to unmapped offsets change no register.
- R11: Read data appears on `reg_rdata` in the cycle after `reg_rd` is sampled and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| eng_start | output | 1 | One-cycle job launch pulse |
| eng_dma | output | 1 | Operand load by DMA selected |
| eng_mode | output | 2 | Operation mode (2 ECC, 3 RSA) |
| eng_exp_bits | output | LEN_W | Exponent length in bits |
| eng_mod_bits | output | LEN_W | Modulus length in bits |
| eng_src_addr | output | 32 | Operand source address |
| eng_xfer_len | output | LEN_W | Operand transfer byte count |
| eng_ready | input | 1 | Engine ready pulse |
| eng_done | input | 1 | Engine complete pulse |
| sram_cpu_sel | output | 1 | Operand SRAM owned by the CPU bus |
| irq | output | 1 | Level interrupt |

## Verification
The mode field is swept over all four values, with junk in the neighbouring bits, to separate field masking from decode. The status clear is tried with every pairing of set flags and clear mask, which distinguishes a write-one-clear from a plain write or a clear-all. The interrupt is tried with every pairing of enables and flags, which exposes any bit swap or missing gate. Start and SRAM grant are driven both idle and busy, so that an ignored start or a premature hand-off shows at the ports.

// File: rtl/rsa_fe_pkg.sv
package rsa_fe_pkg;
  // Register offsets (decoded by software, kept fixed)
  localparam logic [11:0] OFF_CTRL1 = 12'h000;
  localparam logic [11:0] OFF_CTRL3 = 12'h048;
  localparam logic [11:0] OFF_SADDR = 12'h04C;
  localparam logic [11:0] OFF_LEN   = 12'h050;
  localparam logic [11:0] OFF_PARAM = 12'h058;
  localparam logic [11:0] OFF_IEN   = 12'h3F8;
  localparam logic [11:0] OFF_STS   = 12'h3FC;

  // Field positions
  localparam int unsigned C1_START_BIT = 0;
  localparam int unsigned C1_DMA_BIT   = 1;
  localparam int unsigned C3_MODE_LSB  = 4;
  localparam int unsigned C3_SRAM_BIT  = 8;
  localparam int unsigned FLAG_LSB     = 1;   // flags occupy bits 2:1
  localparam int unsigned NFLAGS       = 2;   // [0]=complete, [1]=ready

  typedef enum logic [1:0] {
    MODE_NONE = 2'd0,
    MODE_RSV  = 2'd1,
    MODE_ECC  = 2'd2,
    MODE_RSA  = 2'd3
  } op_mode_e;
endpackage

// File: rtl/rsa_fe_cfg_regs.sv
module rsa_fe_cfg_regs
  import rsa_fe_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       wdata,
  input  logic              we_ctrl3,
  input  logic              we_saddr,
  input  logic              we_len,
  input  logic              we_param,
  input  logic              we_ien,
  output op_mode_e          mode_q,
  output logic              sram_req_q,
  output logic [31:0]       saddr_q,
  output logic [LEN_W-1:0]  len_q,
  output logic [31:0]       param_q,
  output logic [NFLAGS-1:0] ien_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= MODE_NONE;
      sram_req_q <= 1'b0;
      saddr_q    <= '0;
      len_q      <= '0;
      param_q    <= '0;
      ien_q      <= '0;
    end else begin
      if (we_ctrl3) begin
        mode_q     <= op_mode_e'(wdata[C3_MODE_LSB +: 2]);
        sram_req_q <= wdata[C3_SRAM_BIT];
      end
      if (we_saddr) saddr_q <= wdata;
      if (we_len)   len_q   <= wdata[LEN_W-1:0];
      if (we_param) param_q <= wdata;
      if (we_ien)   ien_q   <= wdata[FLAG_LSB +: NFLAGS];
    end
  end
endmodule

// File: rtl/rsa_fe_job.sv
module rsa_fe_job (
  input  logic clk,
  input  logic rst,
  input  logic ctrl1_we,
  input  logic start_bit,
  input  logic dma_bit,
  input  logic done,
  input  logic sram_req,
  output logic start_pulse,
  output logic dma_q,
  output logic busy_q,
  output logic sram_sel_q
);
  logic accept;
  assign accept = ctrl1_we && start_bit && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_pulse <= 1'b0;
      dma_q       <= 1'b0;
      busy_q      <= 1'b0;
      sram_sel_q  <= 1'b0;
    end else begin
      start_pulse <= accept;
      if (ctrl1_we) dma_q <= dma_bit;
      if (accept)    busy_q <= 1'b1;
      else if (done) busy_q <= 1'b0;
      sram_sel_q <= sram_req && !busy_q && !accept;
    end
  end
endmodule

// File: rtl/rsa_fe_status.sv
module rsa_fe_status #(
  parameter int unsigned NF = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set_v,
  input  logic [NF-1:0] clr_v,
  input  logic [NF-1:0] en_v,
  output logic [NF-1:0] flags_q,
  output logic          irq_q
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           flags_q[i] <= 1'b0;
      else if (set_v[i]) flags_q[i] <= 1'b1;
      else if (clr_v[i]) flags_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flags_q & en_v);
  end
endmodule

// File: rtl/rsa_fe_top.sv
module rsa_fe_top
  import rsa_fe_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              eng_start,
  output logic              eng_dma,
  output logic [1:0]        eng_mode,
  output logic [LEN_W-1:0]  eng_exp_bits,
  output logic [LEN_W-1:0]  eng_mod_bits,
  output logic [31:0]       eng_src_addr,
  output logic [LEN_W-1:0]  eng_xfer_len,
  input  logic              eng_ready,
  input  logic              eng_done,
  output logic              sram_cpu_sel,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL1 = ADDR_W'(OFF_CTRL1);
  localparam logic [ADDR_W-1:0] A_CTRL3 = ADDR_W'(OFF_CTRL3);
  localparam logic [ADDR_W-1:0] A_SADDR = ADDR_W'(OFF_SADDR);
  localparam logic [ADDR_W-1:0] A_LEN   = ADDR_W'(OFF_LEN);
  localparam logic [ADDR_W-1:0] A_PARAM = ADDR_W'(OFF_PARAM);
  localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(OFF_IEN);
  localparam logic [ADDR_W-1:0] A_STS   = ADDR_W'(OFF_STS);

  logic              we_ctrl1, we_ctrl3, we_saddr, we_len, we_param, we_ien, we_sts;
  op_mode_e          mode_q;
  logic              sram_req_q;
  logic [31:0]       saddr_q, param_q;
  logic [LEN_W-1:0]  len_q;
  logic [NFLAGS-1:0] ien_q, sts_q, sts_clr;
  logic              job_busy;

  assign we_ctrl1 = reg_wr && (reg_addr == A_CTRL1);
  assign we_ctrl3 = reg_wr && (reg_addr == A_CTRL3);
  assign we_saddr = reg_wr && (reg_addr == A_SADDR);
  assign we_len   = reg_wr && (reg_addr == A_LEN);
  assign we_param = reg_wr && (reg_addr == A_PARAM);
  assign we_ien   = reg_wr && (reg_addr == A_IEN);
  assign we_sts   = reg_wr && (reg_addr == A_STS);
  assign sts_clr  = we_sts ? reg_wdata[FLAG_LSB +: NFLAGS] : '0;

  rsa_fe_cfg_regs #(.LEN_W(LEN_W)) u_cfg (
    .clk(clk), .rst(rst), .wdata(reg_wdata),
    .we_ctrl3(we_ctrl3), .we_saddr(we_saddr), .we_len(we_len),
    .we_param(we_param), .we_ien(we_ien),
    .mode_q(mode_q), .sram_req_q(sram_req_q), .saddr_q(saddr_q),
    .len_q(len_q), .param_q(param_q), .ien_q(ien_q)
  );

  rsa_fe_job u_job (
    .clk(clk), .rst(rst), .ctrl1_we(we_ctrl1),
    .start_bit(reg_wdata[C1_START_BIT]), .dma_bit(reg_wdata[C1_DMA_BIT]),
    .done(eng_done), .sram_req(sram_req_q),
    .start_pulse(eng_start), .dma_q(eng_dma), .busy_q(job_busy),
    .sram_sel_q(sram_cpu_sel)
  );

  rsa_fe_status #(.NF(NFLAGS)) u_sts (
    .clk(clk), .rst(rst), .set_v({eng_ready, eng_done}), .clr_v(sts_clr),
    .en_v(ien_q), .flags_q(sts_q), .irq_q(irq)
  );

  assign eng_mode     = mode_q;
  assign eng_exp_bits = param_q[31:16];
  assign eng_mod_bits = param_q[15:0];
  assign eng_src_addr = saddr_q;
  assign eng_xfer_len = len_q;

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_CTRL1: begin
        rd_mux[C1_START_BIT] = job_busy;
        rd_mux[C1_DMA_BIT]   = eng_dma;
      end
      A_CTRL3: begin
        rd_mux[C3_MODE_LSB +: 2] = mode_q;
        rd_mux[C3_SRAM_BIT]      = sram_req_q;
      end
      A_SADDR: rd_mux = saddr_q;
      A_LEN:   rd_mux[LEN_W-1:0] = len_q;
      A_PARAM: rd_mux = param_q;
      A_IEN:   rd_mux[FLAG_LSB +: NFLAGS] = ien_q;
      A_STS:   rd_mux[FLAG_LSB +: NFLAGS] = sts_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/rsa_fe_chk.sv
module rsa_fe_chk (
  input logic       clk,
  input logic       rst,
  input logic       eng_start,
  input logic       job_busy,
  input logic       eng_done,
  input logic       eng_ready,
  input logic [1:0] sts_q,
  input logic [1:0] ien_q,
  input logic       irq,
  input logic       sram_cpu_sel
);
  // R4: launch pulse lasts one cycle
  p_start_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);
  // R5: a pulse only follows an idle cycle
  p_start_idle_r5: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> !$past(job_busy));
  // R6: completion and ready pulses set their flags
  p_done_flag_r6: assert property (@(posedge clk) disable iff (rst)
    eng_done |=> sts_q[0]);
  p_ready_flag_r6: assert property (@(posedge clk) disable iff (rst)
    eng_ready |=> sts_q[1]);
  // R8: an enabled flag raises the interrupt next cycle
  p_irq_follow_r8: assert property (@(posedge clk) disable iff (rst)
    (|(sts_q & ien_q)) |=> irq);
  // R9: the CPU never owns the SRAM while a job runs
  p_sram_busy_r9: assert property (@(posedge clk) disable iff (rst)
    job_busy |-> !sram_cpu_sel);
endmodule

bind rsa_fe_top rsa_fe_chk u_chk (
  .clk(clk), .rst(rst), .eng_start(eng_start), .job_busy(job_busy),
  .eng_done(eng_done), .eng_ready(eng_ready), .sts_q(sts_q), .ien_q(ien_q),
  .irq(irq), .sram_cpu_sel(sram_cpu_sel)
);

// File: tb/rsa_fe_top_test.sv
`timescale 1ns/1ps
module rsa_fe_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        eng_start, eng_dma;
  logic [1:0]  eng_mode;
  logic [15:0] eng_exp_bits, eng_mod_bits, eng_xfer_len;
  logic [31:0] eng_src_addr;
  logic        eng_ready = 1'b0, eng_done = 1'b0;
  logic        sram_cpu_sel, irq;

  int n_tests = 0, n_fail = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  rsa_fe_top uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_start(eng_start),
    .eng_dma(eng_dma), .eng_mode(eng_mode), .eng_exp_bits(eng_exp_bits),
    .eng_mod_bits(eng_mod_bits), .eng_src_addr(eng_src_addr),
    .eng_xfer_len(eng_xfer_len), .eng_ready(eng_ready), .eng_done(eng_done),
    .sram_cpu_sel(sram_cpu_sel), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a);
    reg_rd = 1'b1; reg_addr = a;
    tick();
    reg_rd = 1'b0;
    rv = reg_rdata;
  endtask

  task automatic pulse(input logic rdy, input logic dn);
    eng_ready = rdy; eng_done = dn;
    tick();
    eng_ready = 1'b0; eng_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();

    // R1: reset state
    begin
      logic [11:0] offs [7] = '{12'h000, 12'h048, 12'h04C, 12'h050, 12'h058, 12'h3F8, 12'h3FC};
      foreach (offs[i]) begin
        rd(offs[i]);
        chk("R1 reg", rv, 0);
      end
    end
    chk("R1 outs", {eng_start, eng_dma, irq, sram_cpu_sel}, 0);

    // R2/R3: mode sweep with junk around the field
    for (int m = 0; m < 4; m++) begin
      wr(12'h048, 32'hFFFF_FECF | (m << 4));
      rd(12'h048);
      chk("R2 ctrl3", rv, m << 4);
      chk("R3 mode", eng_mode, m);
    end
    begin
      logic [31:0] pats [3] = '{32'h0011_0800, 32'hFFFF_0001, 32'h8000_FFFF};
      foreach (pats[i]) begin
        wr(12'h058, pats[i]);
        rd(12'h058);
        chk("R2 param", rv, pats[i]);
        chk("R3 exp", eng_exp_bits, pats[i][31:16]);
        chk("R3 mod", eng_mod_bits, pats[i][15:0]);
      end
    end
    wr(12'h04C, 32'hDEAD_BEE0);
    rd(12'h04C);
    chk("R2 saddr", rv, 32'hDEAD_BEE0);
    chk("R3 src", eng_src_addr, 32'hDEAD_BEE0);
    wr(12'h050, 32'hABCD_0600);
    rd(12'h050);
    chk("R2 len", rv, 32'h0000_0600);
    chk("R3 xfer", eng_xfer_len, 16'h0600);
    wr(12'h3F8, 32'hFFFF_FFFF);
    rd(12'h3F8);
    chk("R2 ien", rv, 32'h6);
    wr(12'h3F8, 0);

    // R10: unmapped offsets
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'h054, 32'hFFFF_FFFF);
    wr(12'h3F4, 32'hFFFF_FFFF);
    rd(12'h054);
    chk("R10 rd0", rv, 0);
    rd(12'h058);
    chk("R10 param kept", rv, 32'h8000_FFFF);
    // R11: read data updates only on a read, then reflects the new offset
    tick();
    chk("R11 hold", reg_rdata, 32'h8000_FFFF);
    rd(12'h3F4);
    chk("R10 rd1", rv, 0);

    // R4: start while idle
    wr(12'h048, 32'h30);
    wr(12'h000, 32'h3);
    chk("R4 start hi", eng_start, 1);
    chk("R4 dma", eng_dma, 1);
    tick();
    chk("R4 start lo", eng_start, 0);
    rd(12'h000);
    chk("R4 ctrl1", rv, 32'h3);

    // R5: start while busy is ignored
    wr(12'h000, 32'h3);
    chk("R5 no pulse", eng_start, 0);
    tick();
    chk("R5 no pulse2", eng_start, 0);
    rd(12'h000);
    chk("R5 busy", rv, 32'h3);

    // R9: grant requested while busy has no effect
    wr(12'h048, 32'h130);
    tick(); tick();
    chk("R9 held busy", sram_cpu_sel, 0);

    // R6: ready then complete
    pulse(1, 0);
    rd(12'h3FC);
    chk("R6 ready", rv, 32'h4);
    rd(12'h000);
    chk("R6 still busy", rv, 32'h3);
    pulse(0, 1);
    chk("R9 lag", sram_cpu_sel, 0);
    tick();
    chk("R9 granted", sram_cpu_sel, 1);
    rd(12'h3FC);
    chk("R6 finished", rv, 32'h6);
    rd(12'h000);
    chk("R6 idle", rv, 32'h2);

    // R9: hand back
    wr(12'h048, 0);
    tick();
    chk("R9 release", sram_cpu_sel, 0);

    // R7: exhaustive set/clear pairs
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 4; c++) begin
        wr(12'h3FC, 32'h6);
        pulse(s[1], s[0]);
        wr(12'h3FC, c << 1);
        rd(12'h3FC);
        chk("R7 w1c", rv, (s & ~c & 3) << 1);
      end
    // R7: set wins over clear
    wr(12'h3FC, 32'h6);
    eng_done = 1'b1;
    wr(12'h3FC, 32'h2);
    eng_done = 1'b0;
    rd(12'h3FC);
    chk("R7 set wins", rv, 32'h2);

    // R8: exhaustive enable/flag pairs
    for (int e = 0; e < 4; e++)
      for (int s = 0; s < 4; s++) begin
        wr(12'h3FC, 32'h6);
        wr(12'h3F8, e << 1);
        pulse(s[1], s[0]);
        tick();
        chk("R8 irq", irq, ((e & s) != 0));
      end
    // R8: one-cycle lag
    wr(12'h3FC, 32'h6);
    wr(12'h3F8, 32'h2);
    tick();
    chk("R8 low", irq, 0);
    pulse(0, 1);
    chk("R8 lag", irq, 0);
    tick();
    chk("R8 up", irq, 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule